// File: doc/BRIEF.md
# Table-Seeded Sine/Cosine Unit

This block returns the cosine and sine of an unsigned fixed-point angle that spans the first quadrant. It starts from a constant table instead of running rotations from zero. The upper bits of the angle select one of a set of equal angle segments. The table holds the cosine and sine of each segment's base angle, already divided by the gain of the rotations still to come.

The lower bits of the angle become a residual angle in radians. A few shift-and-add micro-rotations reduce that residual. The micro-rotations stop at half the word length. One multiply-based linear step then absorbs the small angle that is left.

A caller presents an angle with a one-cycle `start` while the unit is idle. After a fixed number of cycles the unit raises `done` for one cycle and presents both results. The results stay on the outputs until the next result is ready. The unit computes one angle at a time.

Top module: `sincos_seeded`

## Requirements
- R1: While reset is held, and after it is released, `done` is 0 and `cos_out` and `sin_out` are 0.
- R2: A `start` is taken only while the unit is idle. A `start` that arrives during a computation is ignored: the running result is unchanged and no extra `done` follows.
- R3: `done` is high for exactly one cycle. It rises ANG_W/2-SEG_BITS+2 clock edges after the edge that takes `start` (6 with the defaults).
- R4: The input angle encodes angle*(pi/2)/2^ANG_W radians. The outputs are two's complement with ANG_W-2 fraction bits. At segment base angles (all lower ANG_W-SEG_BITS bits zero, including angle 0), both outputs are within 8 LSB of the exact cosine and sine.
- R5: For arbitrary angles, both outputs are within 8 LSB of the exact cosine and sine.
- R6: At the top of a segment (all lower bits one, including the largest angle), both outputs are within 8 LSB. The micro-rotations leave a residual no larger than the arctangent of the last shift plus a few residual LSB.
- R7: Between `done` pulses, `cos_out` and `sin_out` hold their values.
- R8: A `start` given in the same cycle that `done` is high is taken, and it produces a correct result with the same latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to compute the angle on `angle` |
| angle | input | ANG_W | Unsigned angle, full scale is pi/2 |
| done | output | 1 | One-cycle flag: results are valid |
| cos_out | output | ANG_W | Cosine, signed, ANG_W-2 fraction bits |
| sin_out | output | ANG_W | Sine, signed, ANG_W-2 fraction bits |

## Verification
Some properties hold on every cycle, and the assertions watch them:
- `done` lasts one cycle and comes at the fixed distance from acceptance.
- The outputs hold between results.
- The captured angle cannot change once a computation is under way.
- The residual angle is inside the convergence bound when the correction step runs.

Numeric accuracy against exact trigonometry can only be shown by the bench's scenarios. Those scenarios cover segment bases, segment tops and scattered angles. Three further behaviours also need the bench to show them at the ports: a start arriving mid-computation is dropped, a start taken in the done cycle works, and the outputs read zero out of reset.

// File: rtl/sincos_pkg.sv
package sincos_pkg;

  localparam real PI_HALF = 1.5707963267948966;

  typedef enum logic [1:0] {ST_IDLE, ST_LOOK, ST_ITER, ST_CORR} sc_state_t;

  // nearest-integer rounding of a real
  function automatic int rnd(input real v);
    if (v >= 0.0) return $rtoi(v + 0.5);
    return -$rtoi(0.5 - v);
  endfunction

  function automatic real pw2(input int e);
    real r;
    r = 1.0;
    if (e >= 0) for (int i = 0; i < e; i++) r = r * 2.0;
    else        for (int i = 0; i < -e; i++) r = r / 2.0;
    return r;
  endfunction

  // gain of the shift-add rotations that follow the table seed
  function automatic real tail_gain(input int first_sh, input int nstep);
    real g;
    g = 1.0;
    for (int i = 0; i < nstep; i++) g = g * $sqrt(1.0 + pw2(-2 * (first_sh + i)));
    return g;
  endfunction

  function automatic int seed_val(input int seg, input int seg_bits, input int frac,
                                  input int first_sh, input int nstep, input bit want_sin);
    real base;
    real g;
    base = PI_HALF * real'(seg) / pw2(seg_bits);
    g    = tail_gain(first_sh, nstep);
    if (want_sin) return rnd($sin(base) / g * pw2(frac));
    return rnd($cos(base) / g * pw2(frac));
  endfunction

  function automatic int atan_val(input int sh, input int zfrac);
    return rnd($atan(pw2(-sh)) * pw2(zfrac));
  endfunction

endpackage

// File: rtl/sincos_seed_rom.sv
module sincos_seed_rom #(
  parameter int SEG_BITS = 8,
  parameter int W        = 24,
  parameter int FRAC     = 22,
  parameter int FIRST_SH = 8,
  parameter int NSTEP    = 4
) (
  input  logic [SEG_BITS-1:0] seg,
  output logic signed [W-1:0] x0,
  output logic signed [W-1:0] y0
);
  localparam int DEPTH = 1 << SEG_BITS;

  logic signed [W-1:0] cos_tab [DEPTH];
  logic signed [W-1:0] sin_tab [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    localparam int CV = sincos_pkg::seed_val(g, SEG_BITS, FRAC, FIRST_SH, NSTEP, 1'b0);
    localparam int SV = sincos_pkg::seed_val(g, SEG_BITS, FRAC, FIRST_SH, NSTEP, 1'b1);
    assign cos_tab[g] = W'(CV);
    assign sin_tab[g] = W'(SV);
  end

  assign x0 = cos_tab[seg];
  assign y0 = sin_tab[seg];

endmodule

// File: rtl/sincos_micro_rot.sv
module sincos_micro_rot #(
  parameter int W    = 24,
  parameter int ZW   = 24,
  parameter int SH_W = 5
) (
  input  logic signed [W-1:0]  x,
  input  logic signed [W-1:0]  y,
  input  logic signed [ZW-1:0] z,
  input  logic [SH_W-1:0]      sh,
  input  logic signed [ZW-1:0] atan_k,
  output logic signed [W-1:0]  xn,
  output logic signed [W-1:0]  yn,
  output logic signed [ZW-1:0] zn
);
  logic signed [W-1:0] xs, ys;

  assign xs = x >>> sh;
  assign ys = y >>> sh;

  // residual sign picks the rotation direction
  always_comb begin
    if (z[ZW-1]) begin
      xn = x + ys;
      yn = y - xs;
      zn = z + atan_k;
    end else begin
      xn = x - ys;
      yn = y + xs;
      zn = z - atan_k;
    end
  end

endmodule

// File: rtl/sincos_lin_corr.sv
module sincos_lin_corr #(
  parameter int W  = 24,
  parameter int ZW = 24,
  parameter int ZF = 28
) (
  input  logic signed [W-1:0]  x,
  input  logic signed [W-1:0]  y,
  input  logic signed [ZW-1:0] z,
  output logic signed [W-1:0]  xo,
  output logic signed [W-1:0]  yo
);
  localparam int PW = W + ZW;

  logic signed [PW-1:0] yz, xz;

  assign yz = y * z;
  assign xz = x * z;
  assign xo = x - W'(yz >>> ZF);
  assign yo = y + W'(xz >>> ZF);

endmodule

// File: rtl/sincos_seeded.sv
module sincos_seeded #(
  parameter int ANG_W    = 24,
  parameter int SEG_BITS = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [ANG_W-1:0]        angle,
  output logic                    done,
  output logic signed [ANG_W-1:0] cos_out,
  output logic signed [ANG_W-1:0] sin_out
);
  import sincos_pkg::*;

  localparam int W        = ANG_W;
  localparam int FRAC     = ANG_W - 2;
  localparam int NSTEP    = ANG_W / 2 - SEG_BITS;
  localparam int FIRST_SH = SEG_BITS;
  localparam int RES_W    = ANG_W - SEG_BITS;
  localparam int ZW       = ANG_W;
  localparam int ZF       = ANG_W + 4;
  localparam int CQ       = 16;
  localparam int CONV_W   = CQ + 2;
  localparam int CONV     = rnd(PI_HALF * pw2(CQ));
  localparam int CONV_SH  = ANG_W + CQ - ZF;
  localparam int CNT_W    = (NSTEP > 1) ? $clog2(NSTEP) : 1;
  localparam int SH_W     = $clog2(ANG_W);
  localparam int LAT      = NSTEP + 2;
  localparam int LAST_AT  = atan_val(FIRST_SH + NSTEP - 1, ZF);
  localparam int Z_BOUND  = LAST_AT + NSTEP + 2;

  // reset: asserted at once, released on a clock edge
  logic [1:0] rs_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  sc_state_t            state_q, state_n;
  logic [ANG_W-1:0]     ang_q, ang_n;
  logic signed [W-1:0]  x_q, x_n, y_q, y_n;
  logic signed [ZW-1:0] z_q, z_n;
  logic [CNT_W-1:0]     cnt_q, cnt_n;
  logic                 done_n;
  logic signed [W-1:0]  cos_n, sin_n;
  logic                 en_ang, en_xyz, en_out;

  // table seed from the upper angle bits
  logic signed [W-1:0] rom_x, rom_y;

  sincos_seed_rom #(
    .SEG_BITS(SEG_BITS), .W(W), .FRAC(FRAC), .FIRST_SH(FIRST_SH), .NSTEP(NSTEP)
  ) u_rom (
    .seg (ang_q[ANG_W-1 -: SEG_BITS]),
    .x0  (rom_x),
    .y0  (rom_y)
  );

  // lower angle bits to radians with ZF fraction bits
  logic [RES_W+CONV_W-1:0] zprod;
  logic signed [ZW-1:0]    z0;

  assign zprod = ang_q[RES_W-1:0] * CONV_W'(CONV);
  assign z0    = ZW'(zprod >> CONV_SH);

  // arctangent constants for the remaining shifts
  logic signed [ZW-1:0] atan_tab [NSTEP];

  for (genvar k = 0; k < NSTEP; k++) begin : g_atan
    localparam int AV = atan_val(FIRST_SH + k, ZF);
    assign atan_tab[k] = ZW'(AV);
  end

  logic [SH_W-1:0]      sh;
  logic signed [W-1:0]  rot_x, rot_y;
  logic signed [ZW-1:0] rot_z;

  assign sh = SH_W'(FIRST_SH) + SH_W'(cnt_q);

  sincos_micro_rot #(.W(W), .ZW(ZW), .SH_W(SH_W)) u_rot (
    .x      (x_q),
    .y      (y_q),
    .z      (z_q),
    .sh     (sh),
    .atan_k (atan_tab[cnt_q]),
    .xn     (rot_x),
    .yn     (rot_y),
    .zn     (rot_z)
  );

  logic signed [W-1:0] cor_x, cor_y;

  sincos_lin_corr #(.W(W), .ZW(ZW), .ZF(ZF)) u_corr (
    .x  (x_q),
    .y  (y_q),
    .z  (z_q),
    .xo (cor_x),
    .yo (cor_y)
  );

  // next state and enables
  always_comb begin
    state_n = state_q;
    en_ang  = 1'b0;
    en_xyz  = 1'b0;
    en_out  = 1'b0;
    done_n  = 1'b0;
    ang_n   = angle;
    x_n     = rot_x;
    y_n     = rot_y;
    z_n     = rot_z;
    cnt_n   = cnt_q + 1'b1;
    cos_n   = cor_x;
    sin_n   = cor_y;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          en_ang  = 1'b1;
          state_n = ST_LOOK;
        end
      end
      ST_LOOK: begin
        en_xyz  = 1'b1;
        x_n     = rom_x;
        y_n     = rom_y;
        z_n     = z0;
        cnt_n   = '0;
        state_n = ST_ITER;
      end
      ST_ITER: begin
        en_xyz = 1'b1;
        if (cnt_q == CNT_W'(NSTEP - 1)) state_n = ST_CORR;
      end
      ST_CORR: begin
        en_out  = 1'b1;
        done_n  = 1'b1;
        state_n = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      ang_q   <= '0;
      x_q     <= '0;
      y_q     <= '0;
      z_q     <= '0;
      cnt_q   <= '0;
      done    <= 1'b0;
      cos_out <= '0;
      sin_out <= '0;
    end else begin
      state_q <= state_n;
      done    <= done_n;
      if (en_ang) ang_q <= ang_n;
      if (en_xyz) begin
        x_q   <= x_n;
        y_q   <= y_n;
        z_q   <= z_n;
        cnt_q <= cnt_n;
      end
      if (en_out) begin
        cos_out <= cos_n;
        sin_out <= sin_n;
      end
    end
  end

  // latency counter, checked by assertion only
  logic [7:0] lat_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)                      lat_q <= '0;
    else if (state_q == ST_IDLE && start) lat_q <= 8'd1;
    else if (lat_q != 8'd0 && lat_q != 8'hFF) lat_q <= lat_q + 8'd1;
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |=> !done); // R3
  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |-> (lat_q == 8'(LAT + 1))); // R3
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !done |-> ($stable(cos_out) && $stable(sin_out))); // R7
  AST_ANGLE_LOCKED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q != ST_IDLE) |=> $stable(ang_q)); // R2
  AST_RESID_BOUND: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_CORR) |-> (z_q <= Z_BOUND && z_q >= -Z_BOUND)); // R6

endmodule

// File: tb/tb_sincos_seeded.sv
module tb_sincos_seeded;
  localparam int  N     = 24;
  localparam int  M     = 8;
  localparam int  LAT   = N / 2 - M + 2;
  localparam int  TOL   = 8;
  localparam real PI2   = 1.5707963267948966;
  localparam real SCALE = 4194304.0; // 2^(N-2)

  logic                clk;
  logic                rst_n;
  logic                start;
  logic [N-1:0]        angle;
  logic                done;
  logic signed [N-1:0] cos_out, sin_out;

  int checks = 0;
  int errors = 0;

  sincos_seeded #(.ANG_W(N), .SEG_BITS(M)) dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .angle   (angle),
    .done    (done),
    .cos_out (cos_out),
    .sin_out (sin_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic int rnd(input real v);
    if (v >= 0.0) return $rtoi(v + 0.5);
    return -$rtoi(0.5 - v);
  endfunction

  task automatic check_int(input string req, input string what,
                           input int act, input int exp, input int tol);
    checks++;
    if (act - exp > tol || exp - act > tol) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_result(input string req, input logic [N-1:0] a);
    real ar;
    ar = real'(a) * PI2 / (SCALE * 4.0);
    check_int(req, "cos", int'(cos_out), rnd($cos(ar) * SCALE), TOL);
    check_int(req, "sin", int'(sin_out), rnd($sin(ar) * SCALE), TOL);
  endtask

  // drive at a falling edge; returns on the falling edge where done is seen
  task automatic launch(input logic [N-1:0] a, output int lat);
    start = 1'b1;
    angle = a;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic run_one(input string req, input logic [N-1:0] a);
    int lat;
    launch(a, lat);
    check_int("R3", "latency", lat, LAT, 0);
    check_result(req, a);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    start = 1'b0;
    angle = '0;
    repeat (3) @(negedge clk);
    check_int("R1", "done in reset", int'(done), 0, 0);
    check_int("R1", "cos in reset", int'(cos_out), 0, 0);
    check_int("R1", "sin in reset", int'(sin_out), 0, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_int("R1", "done after reset", int'(done), 0, 0);
    check_int("R1", "cos after reset", int'(cos_out), 0, 0);
  endtask

  task automatic t_segment_bases();
    run_one("R4", 24'h000000);
    run_one("R4", 24'h010000);
    run_one("R4", 24'h400000);
    run_one("R4", 24'h800000);
    run_one("R4", 24'hC30000);
    run_one("R4", 24'hFF0000);
  endtask

  task automatic t_segment_tops();
    run_one("R6", 24'h00FFFF);
    run_one("R6", 24'h7FFFFF);
    run_one("R6", 24'hA5FFFF);
    run_one("R6", 24'hFFFFFF);
  endtask

  task automatic t_random();
    for (int i = 0; i < 40; i++) begin
      run_one("R5", N'($urandom));
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic t_busy_ignore();
    int lat;
    int extra;
    logic [N-1:0] a;
    a = 24'h2B7C19;
    start = 1'b1;
    angle = a;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    @(negedge clk);
    lat++;
    start = 1'b1;
    angle = 24'hE01234;
    @(negedge clk);
    lat++;
    start = 1'b0;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    check_int("R2", "latency with mid start", lat, LAT, 0);
    check_result("R2", a);
    extra = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (done) extra++;
    end
    check_int("R2", "extra done pulses", extra, 0, 0);
  endtask

  task automatic t_back_to_back();
    run_one("R8", 24'h123456);
    run_one("R8", 24'h654321);
    run_one("R8", 24'h3F0001);
  endtask

  task automatic t_hold();
    int c0;
    int s0;
    int pulses;
    run_one("R7", 24'h5A5A5A);
    c0 = int'(cos_out);
    s0 = int'(sin_out);
    pulses = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (done) pulses++;
    end
    check_int("R7", "done after result", pulses, 0, 0);
    check_int("R7", "cos held", int'(cos_out), c0, 0);
    check_int("R7", "sin held", int'(sin_out), s0, 0);
  endtask

  initial begin
    t_reset();
    t_segment_bases();
    t_segment_tops();
    t_random();
    t_busy_ignore();
    t_back_to_back();
    t_hold();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule